// File: doc/BRIEF.md
# Convolutional Symbol Interleaver / Deinterleaver

This block spreads a stream of symbols across time so that a burst of channel errors is scattered over many code words once it is put back in order. It holds a set of B parallel delay lines whose lengths form a ladder, with one fixed step between neighbours. An input selector deals each accepted symbol to one line in turn. An output selector, always pointing at the same line, takes the symbol that falls out of that line and presents it on the single output.

A build-time mode picks the direction of the ladder. As an interleaver, line i holds i*STEP symbols, so line 0 is a straight wire. As a deinterleaver, the ladder is reversed: line 0 is the longest at (B-1)*STEP and the last line has no delay. An interleaver followed by a deinterleaver with the same B and STEP therefore delays every symbol by the same amount, (B-1)*STEP*B symbol slots. Symbols move only on cycles with a valid input. Reset empties the lines to zero and points both selectors at line 0.

Top module: `conv_interleaver`

## Requirements
- R1: While reset is high and on the first cycle after it, `outValid` is 0 and `outData` is 0; the first symbol accepted after reset goes to line 0.
- R2: `outValid` equals the value `inValid` had one clock earlier (one register of latency).
- R3: In interleave mode (MODE = MODE_INTERLEAVE), a symbol dealt to line i appears on the output i*STEP visits of that line later; line 0 passes its symbol on with only the one-cycle output register.
- R4: In deinterleave mode (MODE = MODE_DEINTERLEAVE), a symbol dealt to line i appears (B-1-i)*STEP visits of that line later.
- R5: The selector moves to the next line only on a cycle with `inValid` high, and after line B-1 it returns to line 0; accepted symbol number n (counting from 0 after reset) goes to line n mod B.
- R6: On a cycle with `inValid` low no line shifts and `outData` keeps its previous value.
- R7: A position of a delay line that has not yet been filled since reset reads as zero, so the first outputs of a delayed line are zeros.
- R8: An interleaver feeding a deinterleaver with equal parameters returns accepted symbol n on output slot n + (B-1)*STEP*B, with zeros in the slots before that.
- R9: A reset in the middle of a stream discards all held symbols: the outputs afterwards match a freshly reset block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input symbol present this cycle |
| inData | input | WIDTH | Input symbol |
| outValid | output | 1 | Output symbol present this cycle |
| outData | output | WIDTH | Output symbol |

## Verification
The assertions take for granted that `inValid` and `inData` are known values on every clock edge once reset is low, and that reset is held for at least one edge before the stream starts. The stimulus drives both inputs on the falling edge, so they are always settled at the rising edge, and uses non-zero random data so a zero on the output can only come from an unfilled line position. Idle gaps of random length, long back-to-back bursts and a reset in the middle of the stream put the selector at every line at the moment of a pause or a reset.

// File: rtl/cil_pkg.sv
package cil_pkg;

  typedef enum logic {
    MODE_INTERLEAVE   = 1'b0,
    MODE_DEINTERLEAVE = 1'b1
  } cil_mode_e;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // an accepted symbol moves through the selected line
    logic wrapNext;  // the selected line is the last one
  } cil_strobes_t;

endpackage

// File: rtl/cil_ctrl.sv
module cil_ctrl
  import cil_pkg::*;
#(
  parameter int BRANCHES = 4,
  parameter int IDXW     = $clog2(BRANCHES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output cil_strobes_t    strobes,
  output logic [IDXW-1:0] branch,
  output logic            outValid
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BRANCHES - 1);

  always_comb begin
    strobes.shiftEn  = inValid;
    strobes.wrapNext = (branch == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      branch   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        if (branch == LAST_IDX) branch <= '0;
        else                    branch <= branch + 1'b1;
      end
    end
  end

  // R2: one register of latency from input valid to output valid
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R5: the selector steps on valid, wraps after the last line, holds otherwise
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && branch != LAST_IDX) |=> branch == $past(branch) + 1'b1);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && branch == LAST_IDX) |=> branch == '0);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(branch));

endmodule

// File: rtl/cil_delay_line.sv
module cil_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] tap
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) cells[j] <= '0;
    end else if (shift) begin
      cells[0] <= dIn;
      for (int j = 1; j < DEPTH; j++) cells[j] <= cells[j-1];
    end
  end

  // oldest entry is the one leaving on the next shift
  assign tap = cells[DEPTH-1];

  // R6: a line that is not selected keeps its contents
  assert_line_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(tap));

  // R3 R4: the entry entering a line reaches its far end only after DEPTH shifts
  assert_first_cell_R3: assert property (@(posedge clk) disable iff (rst)
    shift |=> cells[0] == $past(dIn));

endmodule

// File: rtl/cil_datapath.sv
module cil_datapath
  import cil_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter int        BRANCHES = 4,
  parameter int        STEP     = 3,
  parameter cil_mode_e MODE     = MODE_INTERLEAVE,
  parameter int        IDXW     = $clog2(BRANCHES)
) (
  input  logic             clk,
  input  logic             rst,
  input  cil_strobes_t     strobes,
  input  logic [IDXW-1:0]  branch,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] outData
);

  logic [WIDTH-1:0] taps [BRANCHES];

  for (genvar i = 0; i < BRANCHES; i++) begin : gLine
    localparam int DEPTH = (MODE == MODE_DEINTERLEAVE) ? (BRANCHES - 1 - i) * STEP
                                                       : i * STEP;
    if (DEPTH == 0) begin : gWire
      assign taps[i] = inData;
    end else begin : gFifo
      logic lineShift;
      assign lineShift = strobes.shiftEn && (branch == IDXW'(i));
      cil_delay_line #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
      ) uLine (
        .clk   (clk),
        .rst   (rst),
        .shift (lineShift),
        .dIn   (inData),
        .tap   (taps[i])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  outData <= '0;
    else if (strobes.shiftEn) outData <= taps[branch];
  end

  // R6: output word holds on idle cycles
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> $stable(outData));

  // R3 R4: the zero-delay line forwards its symbol after one register
  if (MODE == MODE_INTERLEAVE) begin : gWireChkI
    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
      (strobes.shiftEn && branch == '0) |=> outData == $past(inData));
  end else begin : gWireChkD
    assert_passthru_R4: assert property (@(posedge clk) disable iff (rst)
      (strobes.shiftEn && strobes.wrapNext) |=> outData == $past(inData));
  end

endmodule

// File: rtl/conv_interleaver.sv
module conv_interleaver
  import cil_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter int        BRANCHES = 4,
  parameter int        STEP     = 3,
  parameter cil_mode_e MODE     = MODE_INTERLEAVE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);

  localparam int IDXW = (BRANCHES > 1) ? $clog2(BRANCHES) : 1;

  cil_strobes_t    strobes;
  logic [IDXW-1:0] branch;

  cil_ctrl #(
    .BRANCHES (BRANCHES),
    .IDXW     (IDXW)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .branch   (branch),
    .outValid (outValid)
  );

  cil_datapath #(
    .WIDTH    (WIDTH),
    .BRANCHES (BRANCHES),
    .STEP     (STEP),
    .MODE     (MODE),
    .IDXW     (IDXW)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .branch  (branch),
    .inData  (inData),
    .outData (outData)
  );

  // R1: the cycle after reset shows an empty output
  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0));

endmodule

// File: tb/tb_conv_interleaver.sv
module tb_conv_interleaver;
  import cil_pkg::*;

  localparam int W     = 8;
  localparam int NB    = 4;
  localparam int STP   = 3;
  localparam int TOT   = (NB - 1) * STP * NB;
  localparam int HMAX  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic dutValid, deValid;
  logic [W-1:0] dutData, deData;

  always #2 clk = ~clk;

  conv_interleaver #(.WIDTH(W), .BRANCHES(NB), .STEP(STP), .MODE(MODE_INTERLEAVE)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(dutValid), .outData(dutData));

  conv_interleaver #(.WIDTH(W), .BRANCHES(NB), .STEP(STP), .MODE(MODE_DEINTERLEAVE)) deint (
    .clk(clk), .rst(rst), .inValid(dutValid), .inData(dutData),
    .outValid(deValid), .outData(deData));

  logic [W-1:0] histIn  [HMAX];
  logic [W-1:0] histMid [HMAX];
  int kIn, kMid, kDe;
  int nChecks = 0, nFails = 0;
  logic prevValid, prevMid;
  logic [W-1:0] lastDut;

  function automatic logic [W-1:0] expInt(int k);
    int b = k % NB;
    int d = b * STP;
    return ((k / NB) >= d) ? histIn[k - d * NB] : '0;
  endfunction

  function automatic logic [W-1:0] expDe(int k);
    int b = k % NB;
    int d = (NB - 1 - b) * STP;
    return ((k / NB) >= d) ? histMid[k - d * NB] : '0;
  endfunction

  function automatic logic [W-1:0] expChain(int k);
    return (k >= TOT) ? histIn[k - TOT] : '0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (in=%0d mid=%0d de=%0d)",
               req, act, exp, kIn, kMid, kDe);
    end
  endtask

  task automatic observe();
    check("R2 interleaver valid latency", W'(dutValid), W'(prevValid));
    check("R2 deinterleaver valid latency", W'(deValid), W'(prevMid));
    if (dutValid) begin
      // R3 R5 R7: line n mod B, delay (n mod B)*STEP visits, zeros until filled
      check("R3 R5 R7 interleave order", dutData, expInt(kMid));
      histMid[kMid] = dutData;
      kMid++;
    end else begin
      check("R6 interleaver output held", dutData, lastDut);
    end
    lastDut = dutData;
    if (deValid) begin
      check("R4 deinterleave ladder", deData, expDe(kDe));
      check("R8 end-to-end delay", deData, expChain(kDe));
      kDe++;
    end
    prevMid = dutValid;
  endtask

  task automatic step(logic v, logic [W-1:0] d);
    @(negedge clk);
    observe();
    inValid = v;
    inData  = d;
    prevValid = v;
    if (v) begin
      histIn[kIn] = d;
      kIn++;
    end
  endtask

  task automatic doReset(string req);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " outValid in reset"}, W'(dutValid), '0);
    check({req, " outData in reset"}, dutData, '0);
    check({req, " deint outData in reset"}, deData, '0);
    rst = 1'b0;
    kIn = 0; kMid = 0; kDe = 0;
    prevValid = 1'b0; prevMid = 1'b0; lastDut = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    doReset("R1");
    // R1: first symbol goes to line 0 and passes straight through
    step(1'b1, 8'hA5);
    step(1'b0, 8'h00);
    // directed back-to-back burst with distinct non-zero data
    for (int i = 0; i < 80; i++) step(1'b1, W'(i + 1));
    // long idle gap (R6), then all-ones burst
    for (int i = 0; i < 15; i++) step(1'b0, 8'h3C);
    for (int i = 0; i < 20; i++) step(1'b1, 8'hFF);
    // random valid pattern and data
    for (int i = 0; i < 1500; i++)
      step(($urandom % 100) < 65, W'(($urandom % 255) + 1));
    // R9: reset in mid-stream, with the selector at a random line
    for (int i = 0; i < 3; i++) step(1'b1, W'(($urandom % 255) + 1));
    doReset("R9");
    for (int i = 0; i < 1200; i++)
      step(($urandom % 100) < 80, W'(($urandom % 255) + 1));
    // drain
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00);
    if (kDe < TOT + 10) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 too few outputs actual=%0d expected>=%0d", kDe, TOT + 10);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule